// File: doc/BRIEF.md
# Byte-Offset Word Serializer

This block turns a stream of 32-bit memory words into a single serial data line, one bit per bit-clock enable pulse. Words are fetched elsewhere from a word-aligned address (the byte address with its two low bits cleared). Within a word the lowest-addressed byte goes out first, and each byte is sent most significant bit first. The serializer moves from one word to the next with no gap until the stream is aborted.

A byte-addressed read may start at any byte. The two low address bits are captured with the start strobe. They tell the block how many leading bytes of the first word to drop before the first bit goes out. Later words are sent whole. A second mode takes one byte per input transfer and drops nothing, for producers that fetch bytes from an unaligned address.

If no word is offered when the next bit is due, a sticky underflow flag is raised and the output holds. Abort discards any partly sent word, ends the stream and restores the word mode.

Top module: `ssr_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `sdo`, `in_ready`, `underflow` and `busy` are all 0.
- R2: When `busy` is 0, `start` captures `start_off` and `start_bytes` and sets `busy` on the next cycle. A `start` while `busy` is 1 is ignored, and its offset and mode have no effect on the bits sent.
- R3: In word mode, a word `in_data` is sent as `in_data[7:0]`, then `[15:8]`, then `[23:16]`, then `[31:24]`, each byte bit 7 first. A bit appears on `sdo` in the cycle after the `bit_en` cycle that sends it.
- R4: In word mode, the first word after a start skips `start_off` leading bytes (0 to 3), so it begins at byte `start_off`. All later words are sent in full.
- R5: `in_ready` is 1 exactly in cycles where `busy`, `bit_en` and not `abort` hold and no bits of the current word remain. A word accepted in that cycle sends its first bit on the same `bit_en`, so there is no gap across word boundaries.
- R6: In byte mode (`start_bytes`=1 at start), each transfer supplies 8 bits from `in_data[7:0]`, bit 7 first, and `start_off` is ignored.
- R7: If a bit is due but no word is offered, `underflow` is set on the next cycle and stays set until the next accepted start or an abort. `sdo` holds and no bit is consumed.
- R8: `abort` discards all remaining bits, clears `busy` and `underflow`, drives `sdo` to 0 and restores word mode. In the same cycle, `abort` takes priority over `start` and `bit_en`.
- R9: In a cycle with `bit_en` low, `sdo` and the position within the word do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a stream when idle |
| start_off | input | 2 | Low byte-address bits; leading bytes to skip |
| start_bytes | input | 1 | 1 selects one-byte-per-transfer mode |
| abort | input | 1 | Ends the stream and flushes pending bits |
| bit_en | input | 1 | Bit-clock event: send one bit |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_data | input | 32 | Word from memory, byte 0 in bits 7:0 |
| in_ready | output | 1 | The offered word is taken this cycle |
| sdo | output | 1 | Serial data out |
| underflow | output | 1 | Sticky: a bit was due with no word present |
| busy | output | 1 | A stream is running |

## Verification
Several functions can fall in the same cycle. The main cases are a word boundary, where a word load and a bit shift happen on one `bit_en`, and an abort that lands in the same cycle as a start, a bit event or a load. The bench drives these collisions on purpose: an abort together with a start, an abort together with `bit_en` while a word is pending, and random mixes of all inputs. A reference model built on a bit queue predicts every output on every cycle. In each collision it must show abort taking priority and a load that sends its first bit at once.

// File: rtl/ssr_pkg.sv
// Shared definitions for the byte-offset word serializer.
// Assumes words are whole multiples of the byte width.
package ssr_pkg;
    typedef enum logic {
        MODE_WORD = 1'b0,
        MODE_BYTE = 1'b1
    } ser_mode_e;
endpackage

// File: rtl/ssr_lane_align.sv
// Lane aligner: reorders a little-endian memory word so the lowest-addressed
// byte sits at the MSB end, then drops leading bytes by the skip count.
// In byte mode only the low byte is used. Assumes skip < LANES.
module ssr_lane_align #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int OFF_W  = 2,
    parameter int CNT_W  = 6
) (
    input  logic [WORD_W-1:0]   raw,
    input  ssr_pkg::ser_mode_e  mode,
    input  logic [OFF_W-1:0]    skip,
    output logic [WORD_W-1:0]   ld_word,
    output logic [CNT_W-1:0]    ld_cnt
);
    localparam int LANES = WORD_W / BYTE_W;

    logic [WORD_W-1:0] swapped;

    // Byte lane i moves to position i counted from the MSB end.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign swapped[WORD_W-1-i*BYTE_W -: BYTE_W] = raw[i*BYTE_W +: BYTE_W];
    end

    // Select the load pattern and its bit count from the mode and skip.
    always_comb begin
        if (mode == ssr_pkg::MODE_BYTE) begin
            ld_word = {raw[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
            ld_cnt  = CNT_W'(BYTE_W);
        end else begin
            ld_word = swapped << (int'(skip) * BYTE_W);
            ld_cnt  = CNT_W'(WORD_W - int'(skip) * BYTE_W);
        end
    end
endmodule

// File: rtl/ssr_shifter.sv
// Output shifter: holds the current word and sends one bit per step, MSB
// first. When empty it loads the aligned word and sends its first bit on the
// same step. Assumes abort and step are never both high.
module ssr_shifter #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              step,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] ld_word,
    input  logic [CNT_W-1:0]  ld_cnt,
    output logic              empty,
    output logic              take,
    output logic              starve,
    output logic              sdo
);
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;

    assign empty  = (cnt == '0);
    assign take   = step && empty && in_valid;
    assign starve = step && empty && !in_valid;

    // Shift, load or flush the bit register on each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
            sdo <= 1'b0;
        end else if (abort) begin
            sh  <= '0;
            cnt <= '0;
            sdo <= 1'b0;
        end else if (step) begin
            if (!empty) begin
                sdo <= sh[WORD_W-1];
                sh  <= sh << 1;
                cnt <= cnt - 1'b1;
            end else if (in_valid) begin
                sdo <= ld_word[WORD_W-1];
                sh  <= ld_word << 1;
                cnt <= ld_cnt - 1'b1;
            end
        end
    end

    a_r8_abort_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (empty && !sdo));
    a_r7_starve_holds: assert property (@(posedge clk) disable iff (!rst_n)
        starve |=> $stable(sdo));
    a_r9_no_step_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !abort) |=> ($stable(sdo) && $stable(cnt)));
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WORD_W));
endmodule

// File: rtl/ssr_ctrl.sv
// Stream controller: tracks running state, captured mode and offset, whether
// the first word is still pending, and the sticky underflow flag.
// Assumes take and starve come from the shifter and are never high together.
module ssr_ctrl #(
    parameter int OFF_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [OFF_W-1:0]   start_off,
    input  logic               start_bytes,
    input  logic               abort,
    input  logic               take,
    input  logic               starve,
    output logic               running,
    output ssr_pkg::ser_mode_e mode,
    output logic [OFF_W-1:0]   skip,
    output logic               underflow
);
    logic [OFF_W-1:0] off_q;
    logic             first_q;

    assign skip = (first_q && mode == ssr_pkg::MODE_WORD) ? off_q : '0;

    // Stream state: abort wins, start only from idle, loads retire the first word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            mode      <= ssr_pkg::MODE_WORD;
            off_q     <= '0;
            first_q   <= 1'b0;
            underflow <= 1'b0;
        end else if (abort) begin
            running   <= 1'b0;
            mode      <= ssr_pkg::MODE_WORD;
            first_q   <= 1'b0;
            underflow <= 1'b0;
        end else if (!running) begin
            if (start) begin
                running   <= 1'b1;
                mode      <= start_bytes ? ssr_pkg::MODE_BYTE : ssr_pkg::MODE_WORD;
                off_q     <= start_off;
                first_q   <= 1'b1;
                underflow <= 1'b0;
            end
        end else begin
            if (take)   first_q   <= 1'b0;
            if (starve) underflow <= 1'b1;
        end
    end

    a_r2_offset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !abort) |=> ($stable(off_q) && $stable(mode)));
    a_r8_abort_default: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!running && mode == ssr_pkg::MODE_WORD && !underflow));
    a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (starve && !abort) |=> underflow);
    a_r4_skip_once: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (skip == '0));
endmodule

// File: rtl/ssr_top.sv
// Byte-offset word serializer top: joins the controller, lane aligner and
// shifter. A word is taken only on a bit event that finds the shifter empty.
// Assumes in_data is held stable while in_valid is high and not taken.
module ssr_top #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        start_off,
    input  logic              start_bytes,
    input  logic              abort,
    input  logic              bit_en,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              sdo,
    output logic              underflow,
    output logic              busy
);
    localparam int LANES = WORD_W / BYTE_W;
    localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CNT_W = $clog2(WORD_W + 1);

    ssr_pkg::ser_mode_e mode;
    logic [OFF_W-1:0]   skip;
    logic [WORD_W-1:0]  ld_word;
    logic [CNT_W-1:0]   ld_cnt;
    logic               running, step, empty, take, starve;

    assign step     = bit_en && running && !abort;
    assign in_ready = step && empty;
    assign busy     = running;

    ssr_ctrl #(.OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_off(OFF_W'(start_off)), .start_bytes(start_bytes),
        .abort(abort), .take(take), .starve(starve),
        .running(running), .mode(mode), .skip(skip), .underflow(underflow)
    );

    ssr_lane_align #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_align (
        .raw(in_data), .mode(mode), .skip(skip), .ld_word(ld_word), .ld_cnt(ld_cnt)
    );

    ssr_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .abort(abort), .step(step), .in_valid(in_valid),
        .ld_word(ld_word), .ld_cnt(ld_cnt), .empty(empty), .take(take),
        .starve(starve), .sdo(sdo)
    );

    a_r5_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && bit_en));
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!sdo && !underflow && !busy));
endmodule

// File: tb/ssr_top_bench.sv
// Cycle-by-cycle bench: a bit-queue reference model predicts every output.
module ssr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, start_bytes = 1'b0, abort = 1'b0;
    logic        bit_en = 1'b0, in_valid = 1'b0;
    logic [1:0]  start_off = 2'd0;
    logic [31:0] in_data = '0;
    logic        in_ready, sdo, underflow, busy;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    // Reference model state
    bit       m_run = 0, m_bytes = 0, m_first = 0, m_sdo = 0, m_uf = 0;
    int       m_off = 0;
    bit       bitq[$];

    always #2 clk = ~clk;

    ssr_top u_ssr_top (
        .clk(clk), .rst_n(rst_n), .start(start), .start_off(start_off),
        .start_bytes(start_bytes), .abort(abort), .bit_en(bit_en),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .sdo(sdo), .underflow(underflow), .busy(busy)
    );

    // Reference model update on each clock edge.
    always @(posedge clk) begin
        if (!rst_n || abort) begin
            m_run = 0; m_bytes = 0; m_first = 0; m_sdo = 0; m_uf = 0;
            bitq.delete();
        end else if (!m_run) begin
            if (start) begin
                m_run = 1; m_bytes = start_bytes; m_off = int'(start_off);
                m_first = 1; m_uf = 0;
            end
        end else if (bit_en) begin
            if (bitq.size() == 0) begin
                if (in_valid) begin
                    if (m_bytes) begin
                        for (int k = 7; k >= 0; k--) bitq.push_back(in_data[k]);
                    end else begin
                        for (int b = (m_first ? m_off : 0); b < 4; b++)
                            for (int k = 7; k >= 0; k--) bitq.push_back(in_data[b*8+k]);
                    end
                    m_first = 0;
                end else begin
                    m_uf = 1;
                end
            end
            if (bitq.size() != 0) m_sdo = bitq.pop_front();
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One bench cycle: check registered outputs, drive inputs, check in_ready.
    task automatic cyc(input logic st, input logic [1:0] off, input logic by,
                       input logic ab, input logic be, input logic iv);
        @(negedge clk);
        chk("sdo", sdo, m_sdo);
        chk("underflow", underflow, m_uf);
        chk("busy", busy, m_run);
        start = st; start_off = off; start_bytes = by;
        abort = ab; bit_en = be; in_valid = iv; in_data = $urandom;
        #1;
        chk("in_ready", in_ready, m_run && bit_en && bitq.size() == 0 && !abort);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(13));
        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 1);
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 0);
        // R3: aligned word stream, continuous bit_en
        tag = "R3";
        cyc(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 80; i++) cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 1, 0, 0);
        // R4: each skip value
        tag = "R4";
        for (int o = 0; o < 4; o++) begin
            cyc(1, 2'(o), 0, 0, 0, 0);
            for (int i = 0; i < 50; i++) cyc(0, 0, 0, 0, 1, 1);
            cyc(0, 0, 0, 1, 0, 0);
        end
        // R2: start while running is ignored
        tag = "R2";
        cyc(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) cyc((i % 5) == 0, 3, 1, 0, 1, 1);
        cyc(0, 0, 0, 1, 0, 0);
        // R6: byte mode ignores offset
        tag = "R6";
        cyc(1, 3, 1, 0, 0, 0);
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 1, 0, 0);
        // R8: mode restored after abort; abort beats start and bit_en
        tag = "R8";
        cyc(1, 2, 0, 0, 0, 0);
        for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 1, 1);
        cyc(1, 1, 1, 1, 1, 1);
        cyc(0, 0, 0, 0, 1, 1);
        cyc(1, 0, 0, 1, 0, 0);
        // R7: underflow and its clearing
        tag = "R7";
        cyc(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 45; i++) cyc(0, 0, 0, 0, 1, (i < 20) || (i > 40));
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        // R9: sparse bit_en
        tag = "R9";
        cyc(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 120; i++) cyc(0, 0, 0, 0, (i % 3) == 0, 1);
        cyc(0, 0, 0, 1, 0, 0);
        // R5: random mix of all inputs
        tag = "R5";
        for (int i = 0; i < 4000; i++)
            cyc(($urandom % 16) == 0, 2'($urandom), ($urandom % 4) == 0,
                ($urandom % 60) == 0, ($urandom % 4) != 0, ($urandom % 6) != 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule